// File: doc/BRIEF.md
# Day-Hour-Minute-Second Clock Counter

This block keeps time of day as a chain of cascaded counters: seconds, minutes, hours and a 9-bit day count. A one-cycle tick enable advances the chain once per second. Five byte-wide registers hold the live count. The register at index 4 is a flag byte. It carries the top bit of the day count, a halt control and a sticky day-overflow flag.

A separate shadow copy of the five registers is what the read port returns. A latch strobe refreshes the whole shadow set from the live counters in a single cycle. Software can therefore read a consistent time while the counters keep running. A write port loads one register at a time. Each write updates both the live register and its shadow, so the written value can be read back at once. The one-second tick comes from outside the block, and so does all bus address decoding.

Top module: `tod_clock_counter`

## Requirements
- R1: After reset every live and shadow register is zero, so rd_data reads 0x00 for indices 0 to 4.
- R2: The seconds register (index 0) advances by one on each enabled tick. When a tick arrives at 59 it goes to 0 and advances the minutes.
- R3: The minutes register (index 1) goes from 59 to 0 and carries into the hours register (index 2). The hours register goes from 23 to 0 and carries into the day count.
- R4: The day count is 9 bits wide. Its low 8 bits are register 3 and its bit 8 is bit 0 of register 4. A carry at a low byte of 0xFF clears the low byte and carries into bit 0 of register 4. A carry at 511 wraps the count to 0 and sets bit 7 of register 4.
- R5: Bit 7 of register 4 stays set through further ticks and latches. It is cleared only by a write to register 4 with bit 7 at 0.
- R6: While bit 6 of register 4 is set, ticks are ignored and every counter holds.
- R7: A latch strobe copies all five live registers into the shadow set at that clock edge. rd_data shows only shadow values, so ticks are not visible until the next latch.
- R8: A write loads the same value into the live register and into its shadow. Stored field widths are 6 bits for indices 0 and 1 and 5 bits for index 2. Index 4 keeps only bits 0, 6 and 7; its other bits read as 0. A write to indices 5 to 7 changes nothing.
- R9: When a write and a tick fall in the same cycle, the written register takes the written value. The other registers still advance, with carries taken from the values before the write. When a write and a latch coincide, the written register's shadow takes the write data.
- R10: rd_idx values 5 to 7 return 0xFF.
- R11: A seconds, minutes or hours value written above its limit keeps counting within its field width. At the field maximum it wraps to 0 and produces no carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle advance enable, once per second |
| latch_stb | input | 1 | Copy all live registers into the shadow set |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 8 | Write value |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 8 | Shadow register value at rd_idx |

## Verification
The assertions assume that tick_1hz, latch_stb and wr_en are single-cycle strobes sampled at the rising edge. Several properties also assume that no write lands in the same cycle as the behaviour they check. Each property is therefore guarded by the absence of a write, or of a write to the register concerned. The bench drives every strobe for exactly one clock and changes inputs only on the falling edge. It puts writes next to ticks or latches only in the directed same-cycle tests.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 3;
    localparam int NUM_REGS = 5;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    localparam int DAY_W    = 9;

    localparam logic [IDX_W-1:0] IX_SEC  = 3'd0;
    localparam logic [IDX_W-1:0] IX_MIN  = 3'd1;
    localparam logic [IDX_W-1:0] IX_HR   = 3'd2;
    localparam logic [IDX_W-1:0] IX_DAYL = 3'd3;
    localparam logic [IDX_W-1:0] IX_FLAG = 3'd4;

    localparam int FLG_DAYHI = 0;
    localparam int FLG_HALT  = 6;
    localparam int FLG_OVF   = 7;

    localparam logic [BYTE_W-1:0] IDLE_READ = 8'hFF;

    function automatic logic [BYTE_W-1:0] field_mask(input logic [IDX_W-1:0] idx);
        logic [BYTE_W-1:0] m;
        unique case (idx)
            IX_SEC:  m = BYTE_W'((1 << SEC_W) - 1);
            IX_MIN:  m = BYTE_W'((1 << MIN_W) - 1);
            IX_HR:   m = BYTE_W'((1 << HR_W) - 1);
            IX_DAYL: m = '1;
            IX_FLAG: m = BYTE_W'((1 << FLG_OVF) | (1 << FLG_HALT) | (1 << FLG_DAYHI));
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tod_wrap_counter.sv
module tod_wrap_counter #(
    parameter int WIDTH = 6,
    parameter int LIMIT = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] count,
    output logic             carry
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(LIMIT - 1);

    assign carry = inc && (count == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld) begin
            count <= ld_val;
        end else if (inc) begin
            count <= (count == LAST) ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/tod_day_counter.sv
module tod_day_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              ld_lo,
    input  logic              ld_flags,
    input  logic [BYTE_W-1:0] ld_val,
    output logic [DAY_W-1:0]  day_q,
    output logic              halt_q,
    output logic              ovf_q
);
    localparam logic [DAY_W-1:0] DAY_MAX = '1;

    logic [DAY_W-1:0] day_inc;
    logic             wraps;

    assign day_inc = inc ? day_q + 1'b1 : day_q;
    assign wraps   = inc && (day_q == DAY_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_q  <= '0;
            halt_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            day_q[BYTE_W-1:0] <= ld_lo ? ld_val : day_inc[BYTE_W-1:0];
            if (ld_flags) begin
                day_q[DAY_W-1] <= ld_val[FLG_DAYHI];
                halt_q         <= ld_val[FLG_HALT];
                ovf_q          <= ld_val[FLG_OVF];
            end else begin
                day_q[DAY_W-1] <= day_inc[DAY_W-1];
                ovf_q          <= ovf_q | wraps;
            end
        end
    end
endmodule

// File: rtl/tod_shadow_bank.sv
module tod_shadow_bank
    import tod_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             latch,
    input  logic [NUM_REGS-1:0]              wr_hit,
    input  logic [BYTE_W-1:0]                wr_val,
    input  logic [NUM_REGS-1:0][BYTE_W-1:0]  live_in,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]  shadow_q,
    output logic [BYTE_W-1:0]                rd_data
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[i] <= '0;
            end else if (wr_hit[i]) begin
                shadow_q[i] <= wr_val & field_mask(IDX_W'(i));
            end else if (latch) begin
                shadow_q[i] <= live_in[i];
            end
        end
    end

    always_comb begin
        rd_data = IDLE_READ;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = shadow_q[i];
        end
    end
endmodule

// File: rtl/tod_clock_counter.sv
module tod_clock_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              latch_stb,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);
    logic [NUM_REGS-1:0]             wr_hit;
    logic [NUM_REGS-1:0][BYTE_W-1:0] live_bytes;
    logic [NUM_REGS-1:0][BYTE_W-1:0] shadow_bytes;
    logic [SEC_W-1:0] sec_q;
    logic [MIN_W-1:0] min_q;
    logic [HR_W-1:0]  hr_q;
    logic [DAY_W-1:0] day_q;
    logic halt_q, ovf_q;
    logic tick_ok, sec_cy, min_cy, hr_cy;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign wr_hit[i] = wr_en && (wr_idx == IDX_W'(i));
    end

    assign tick_ok = tick_1hz && !halt_q;

    tod_wrap_counter #(.WIDTH(SEC_W), .LIMIT(60)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(tick_ok), .ld(wr_hit[IX_SEC]),
        .ld_val(wr_data[SEC_W-1:0]), .count(sec_q), .carry(sec_cy));

    tod_wrap_counter #(.WIDTH(MIN_W), .LIMIT(60)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(sec_cy), .ld(wr_hit[IX_MIN]),
        .ld_val(wr_data[MIN_W-1:0]), .count(min_q), .carry(min_cy));

    tod_wrap_counter #(.WIDTH(HR_W), .LIMIT(24)) u_hr (
        .clk(clk), .rst_n(rst_n), .inc(min_cy), .ld(wr_hit[IX_HR]),
        .ld_val(wr_data[HR_W-1:0]), .count(hr_q), .carry(hr_cy));

    tod_day_counter u_day (
        .clk(clk), .rst_n(rst_n), .inc(hr_cy), .ld_lo(wr_hit[IX_DAYL]),
        .ld_flags(wr_hit[IX_FLAG]), .ld_val(wr_data),
        .day_q(day_q), .halt_q(halt_q), .ovf_q(ovf_q));

    always_comb begin
        live_bytes          = '0;
        live_bytes[IX_SEC]  = BYTE_W'(sec_q);
        live_bytes[IX_MIN]  = BYTE_W'(min_q);
        live_bytes[IX_HR]   = BYTE_W'(hr_q);
        live_bytes[IX_DAYL] = day_q[BYTE_W-1:0];
        live_bytes[IX_FLAG][FLG_DAYHI] = day_q[DAY_W-1];
        live_bytes[IX_FLAG][FLG_HALT]  = halt_q;
        live_bytes[IX_FLAG][FLG_OVF]   = ovf_q;
    end

    tod_shadow_bank u_bank (
        .clk(clk), .rst_n(rst_n), .latch(latch_stb), .wr_hit(wr_hit),
        .wr_val(wr_data), .live_in(live_bytes), .rd_idx(rd_idx),
        .shadow_q(shadow_bytes), .rd_data(rd_data));
endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker
    import tod_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             tick_1hz,
    input logic                             latch_stb,
    input logic                             wr_en,
    input logic [IDX_W-1:0]                 wr_idx,
    input logic [BYTE_W-1:0]                wr_data,
    input logic [IDX_W-1:0]                 rd_idx,
    input logic [BYTE_W-1:0]                rd_data,
    input logic [NUM_REGS-1:0][BYTE_W-1:0]  live_bytes,
    input logic [NUM_REGS-1:0][BYTE_W-1:0]  shadow_bytes
);
    // R7
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && !wr_en) |=> shadow_bytes == $past(live_bytes));

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_bytes[IX_FLAG][FLG_HALT] && !wr_en) |=> live_bytes == $past(live_bytes));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !live_bytes[IX_FLAG][FLG_HALT] && !wr_en && live_bytes[IX_SEC] < 8'd59)
        |=> live_bytes[IX_SEC] == BYTE_W'($past(live_bytes[IX_SEC]) + 8'd1));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_bytes[IX_FLAG][FLG_OVF] && !(wr_en && wr_idx == IX_FLAG))
        |=> live_bytes[IX_FLAG][FLG_OVF]);

    // R8
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IX_SEC)
        |=> (live_bytes[IX_SEC] == ($past(wr_data) & 8'h3F))
            && (shadow_bytes[IX_SEC] == ($past(wr_data) & 8'h3F)));

    // R8
    wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > IX_FLAG && !tick_1hz && !latch_stb)
        |=> $stable(live_bytes) && $stable(shadow_bytes));

    // R10
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx > IX_FLAG) |-> rd_data == IDLE_READ);
endmodule

bind tod_clock_counter tod_clock_checker u_chk (.*);

// File: tb/tb_tod_clock_counter.sv
module tb_tod_clock_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0, latch_stb = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_idx = '0, rd_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tod_clock_counter dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .latch_stb(latch_stb), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data));

    localparam logic [1:0] OP_WR = 2'd0, OP_TK = 2'd1, OP_LT = 2'd2, OP_CK = 2'd3;
    localparam int NV = 59;
    // entry: {req, op, idx, value}
    localparam logic [16:0] VEC [0:NV-1] = '{
        {4'd8, OP_WR, 3'd0, 8'd58}, {4'd8, OP_WR, 3'd1, 8'd59},
        {4'd8, OP_WR, 3'd2, 8'd23}, {4'd8, OP_WR, 3'd3, 8'hFF},
        {4'd8, OP_WR, 3'd4, 8'h00},
        {4'd8, OP_CK, 3'd0, 8'd58}, {4'd8, OP_CK, 3'd2, 8'd23},  // R8
        {4'd7, OP_TK, 3'd0, 8'd0},  {4'd7, OP_CK, 3'd0, 8'd58},  // R7 no latch yet
        {4'd7, OP_LT, 3'd0, 8'd0},  {4'd2, OP_CK, 3'd0, 8'd59},  // R2 R7
        {4'd2, OP_TK, 3'd0, 8'd0},  {4'd2, OP_LT, 3'd0, 8'd0},
        {4'd2, OP_CK, 3'd0, 8'd0},  {4'd3, OP_CK, 3'd1, 8'd0},   // R2 R3
        {4'd3, OP_CK, 3'd2, 8'd0},  {4'd4, OP_CK, 3'd3, 8'd0},   // R3 R4
        {4'd4, OP_CK, 3'd4, 8'h01},
        {4'd4, OP_WR, 3'd3, 8'hFF}, {4'd4, OP_WR, 3'd0, 8'd59},
        {4'd4, OP_WR, 3'd1, 8'd59}, {4'd4, OP_WR, 3'd2, 8'd23},
        {4'd4, OP_TK, 3'd0, 8'd0},  {4'd4, OP_LT, 3'd0, 8'd0},
        {4'd4, OP_CK, 3'd3, 8'd0},  {4'd4, OP_CK, 3'd4, 8'h80},  // R4 511 wrap
        {4'd5, OP_TK, 3'd0, 8'd0},  {4'd5, OP_LT, 3'd0, 8'd0},
        {4'd5, OP_CK, 3'd0, 8'd1},  {4'd5, OP_CK, 3'd4, 8'h80},  // R5 sticky
        {4'd5, OP_WR, 3'd4, 8'h00}, {4'd5, OP_CK, 3'd4, 8'h00},  // R5 clear
        {4'd6, OP_WR, 3'd4, 8'h40}, {4'd6, OP_WR, 3'd0, 8'd10},
        {4'd6, OP_TK, 3'd0, 8'd0},  {4'd6, OP_TK, 3'd0, 8'd0},
        {4'd6, OP_LT, 3'd0, 8'd0},  {4'd6, OP_CK, 3'd0, 8'd10},  // R6 halted
        {4'd6, OP_CK, 3'd4, 8'h40},
        {4'd6, OP_WR, 3'd4, 8'h00}, {4'd6, OP_TK, 3'd0, 8'd0},
        {4'd6, OP_LT, 3'd0, 8'd0},  {4'd6, OP_CK, 3'd0, 8'd11},  // R6 resumed
        {4'd8, OP_WR, 3'd0, 8'hFF}, {4'd8, OP_CK, 3'd0, 8'h3F},  // R8 width
        {4'd8, OP_WR, 3'd2, 8'hFF}, {4'd8, OP_CK, 3'd2, 8'h1F},
        {4'd11, OP_WR, 3'd0, 8'd63}, {4'd11, OP_WR, 3'd1, 8'd5},
        {4'd11, OP_TK, 3'd0, 8'd0}, {4'd11, OP_LT, 3'd0, 8'd0},
        {4'd11, OP_CK, 3'd0, 8'd0}, {4'd11, OP_CK, 3'd1, 8'd5},  // R11
        {4'd8, OP_WR, 3'd4, 8'hFF}, {4'd8, OP_CK, 3'd4, 8'hC1},  // R8 flags
        {4'd8, OP_WR, 3'd4, 8'h00}, {4'd8, OP_CK, 3'd4, 8'h00},
        {4'd8, OP_CK, 3'd3, 8'd0},  {4'd8, OP_CK, 3'd3, 8'd0}
    };

    task automatic check(input logic [2:0] idx, input logic [7:0] exp, input string req);
        rd_idx = idx;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s idx %0d actual %02h expected %02h", req, idx, rd_data, exp);
        end
    endtask

    task automatic strobe(input bit t, input bit l, input bit w,
                          input logic [2:0] idx, input logic [7:0] val);
        @(negedge clk);
        tick_1hz = t; latch_stb = l; wr_en = w; wr_idx = idx; wr_data = val;
        @(negedge clk);
        tick_1hz = 1'b0; latch_stb = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int i = 0; i < 5; i++) check(3'(i), 8'h00, "R1");
        for (int i = 5; i < 8; i++) check(3'(i), 8'hFF, "R10");

        for (int v = 0; v < NV; v++) begin
            logic [16:0] e = VEC[v];
            string rq = $sformatf("R%0d", e[16:13]);
            unique case (e[12:11])
                OP_WR: strobe(1'b0, 1'b0, 1'b1, e[10:8], e[7:0]);
                OP_TK: strobe(1'b1, 1'b0, 1'b0, 3'd0, 8'd0);
                OP_LT: strobe(1'b0, 1'b1, 1'b0, 3'd0, 8'd0);
                OP_CK: check(e[10:8], e[7:0], rq);
            endcase
        end

        // R8: write to index 6 changes nothing
        strobe(1'b0, 1'b0, 1'b1, 3'd0, 8'd12);
        strobe(1'b0, 1'b0, 1'b1, 3'd6, 8'h33);
        strobe(1'b0, 1'b1, 1'b0, 3'd0, 8'd0);
        check(3'd0, 8'd12, "R8");
        check(3'd6, 8'hFF, "R8");

        // R9: write seconds together with a tick at 59
        strobe(1'b0, 1'b0, 1'b1, 3'd1, 8'd20);
        strobe(1'b0, 1'b0, 1'b1, 3'd0, 8'd59);
        strobe(1'b1, 1'b0, 1'b1, 3'd0, 8'd30);
        strobe(1'b0, 1'b1, 1'b0, 3'd0, 8'd0);
        check(3'd0, 8'd30, "R9");
        check(3'd1, 8'd21, "R9");
        // R9: write minutes together with a latch
        strobe(1'b0, 1'b1, 1'b1, 3'd1, 8'd7);
        check(3'd1, 8'd7, "R9");
        check(3'd0, 8'd30, "R9");

        // R1 again after a mid-run reset, then a long run (R2 R3)
        do_reset();
        check(3'd0, 8'h00, "R1");
        check(3'd1, 8'h00, "R1");
        for (int k = 0; k < 3661; k++) strobe(1'b1, 1'b0, 1'b0, 3'd0, 8'd0);
        strobe(1'b0, 1'b1, 1'b0, 3'd0, 8'd0);
        check(3'd0, 8'd1, "R2");
        check(3'd1, 8'd1, "R3");
        check(3'd2, 8'd1, "R3");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule